// File: doc/BRIEF.md
# PC Card Access Timing Generator

This block times a single access to a PC Card socket. It is mapped onto a memory region that has been set up for card-style devices. A request carries the access type (memory or IO, read or write), an attribute-space flag, the port width and the byte enables. It also carries four timing selections: a setup code, a hold code, a card wait code, and the base wait count of the region.

Once the block has accepted a request, it runs the card enables through three phases. The setup phase comes before the strobe and the hold phase comes after it. The strobe itself is one of four: output enable, write enable, IO read or IO write. The register-space select pin stays asserted for the whole access when the attribute flag is set. The strobe lasts for the base wait plus the card wait plus one cycle. A low ready input stretches it further.

The control pins are active-low. Four of them take the place of general byte-write pins.

Top module: `pcc_access_gen`

## Requirements
- R1: After reset, and whenever `busy_o` is low, every active-low control output is high.
- R2: The setup code selects 0, 1, 2 or 15 cycles (codes 0..3) during which a card enable is low and no strobe is active, before the strobe begins.
- R3: The hold code selects 0, 1, 2 or 15 cycles (codes 0..3) during which a card enable stays low after the strobe ends.
- R4: The strobe is low for base_wait + card_wait + 1 cycles. The card wait code maps to 0, 15, 30 or 50 extra cycles (codes 0..3) and is added to the 4-bit base wait.
- R5: While `ready_i` is low in the last counted strobe cycle, the strobe is held for one more cycle per such cycle. `ready_i` is ignored in every other cycle.
- R6: The strobe is chosen by the access type and only one strobe is ever low. A memory read drives `oe_n_o`, a memory write drives `we_n_o`, an IO read drives `iord_n_o` and an IO write drives `iowr_n_o`.
- R7: `reg_n_o` is low for every cycle of an access whose attribute flag was set, from the first setup cycle to the last hold cycle. It stays high for all other accesses.
- R8: With `wide_i` low (8-bit), only `ce1_n_o` goes low, whatever the byte enables are. With `wide_i` high (16-bit), `ce1_n_o` follows `be_i[0]` and `ce2_n_o` follows `be_i[1]`.
- R9: The block captures all request fields when it accepts a request in idle. A request raised while `busy_o` is high is ignored, and input changes during an access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start an access (sampled while idle) |
| io_i | input | 1 | 1 = IO space, 0 = memory space |
| write_i | input | 1 | 1 = write, 0 = read |
| attr_i | input | 1 | Attribute-space access (drives register select) |
| wide_i | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| be_i | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| setup_code_i | input | 2 | Setup length code |
| hold_code_i | input | 2 | Hold length code |
| cwait_code_i | input | 2 | Card wait code |
| base_wait_i | input | 4 | Region base wait count |
| ready_i | input | 1 | Card ready; low stretches the strobe |
| busy_o | output | 1 | Access in progress |
| ce1_n_o | output | 1 | Low-byte card enable |
| ce2_n_o | output | 1 | High-byte card enable |
| oe_n_o | output | 1 | Memory read strobe |
| we_n_o | output | 1 | Memory write strobe |
| iord_n_o | output | 1 | IO read strobe |
| iowr_n_o | output | 1 | IO write strobe |
| reg_n_o | output | 1 | Register/attribute space select |

## Verification
The check that a strobe always falls inside a card enable relies on a 16-bit access never arriving with both byte enables clear. The stimulus therefore always sets at least one enable bit whenever `wide_i` is high. The ready stretch check relies on `ready_i` only mattering once the wait count has run out. The bench lowers ready before the request and raises it in a strobe cycle that it computes from the requirement arithmetic, so that the exact number of stretch cycles is known. Requests arriving during an access are only ever single-cycle pulses while `busy_o` is high. All other input changes made during an access are scrambled values that the captured access must not show.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;

   localparam int unsigned MAP_FW = 8;   // width of one entry in a code map
   localparam int unsigned MAP_N  = 4;   // entries per map (2-bit code)

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD
   } pcc_state_e;

   typedef struct packed {
      logic       io;
      logic       wr;
      logic       attr;
      logic       wide;
      logic [1:0] be;
   } pcc_attr_t;

   function automatic int unsigned map_max(input logic [MAP_N*MAP_FW-1:0] m);
      int unsigned r;
      r = 0;
      for (int i = 0; i < MAP_N; i++) begin
         if (32'(m[i*MAP_FW +: MAP_FW]) > r) r = 32'(m[i*MAP_FW +: MAP_FW]);
      end
      return r;
   endfunction

endpackage

// File: rtl/pcc_decode.sv
`timescale 1ns/1ps
module pcc_decode
   import pcc_pkg::*;
#(
   parameter int unsigned                  BASE_W    = 4,
   parameter int unsigned                  CNT_W     = 7,
   parameter logic [MAP_N*MAP_FW-1:0]      SETUP_MAP = {8'd15, 8'd2, 8'd1, 8'd0},
   parameter logic [MAP_N*MAP_FW-1:0]      HOLD_MAP  = {8'd15, 8'd2, 8'd1, 8'd0},
   parameter logic [MAP_N*MAP_FW-1:0]      WAIT_MAP  = {8'd50, 8'd30, 8'd15, 8'd0}
) (
   input  logic [1:0]        su_code_i,
   input  logic [1:0]        ho_code_i,
   input  logic [1:0]        cw_code_i,
   input  logic [BASE_W-1:0] base_i,
   output logic [CNT_W-1:0]  su_o,
   output logic [CNT_W-1:0]  ho_o,
   output logic [CNT_W-1:0]  st_o
);

   logic [CNT_W-1:0] su_tab [MAP_N];
   logic [CNT_W-1:0] ho_tab [MAP_N];
   logic [CNT_W-1:0] cw_tab [MAP_N];

   for (genvar i = 0; i < MAP_N; i++) begin : g_tab
      assign su_tab[i] = CNT_W'(SETUP_MAP[i*MAP_FW +: MAP_FW]);
      assign ho_tab[i] = CNT_W'(HOLD_MAP[i*MAP_FW +: MAP_FW]);
      assign cw_tab[i] = CNT_W'(WAIT_MAP[i*MAP_FW +: MAP_FW]);
   end

   assign su_o = su_tab[su_code_i];
   assign ho_o = ho_tab[ho_code_i];
   // strobe count = region base wait + card wait (the +1 cycle is the count-0 cycle)
   assign st_o = CNT_W'(base_i) + cw_tab[cw_code_i];

endmodule

// File: rtl/pcc_fsm.sv
`timescale 1ns/1ps
module pcc_fsm
   import pcc_pkg::*;
#(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             ready_i,
   input  pcc_attr_t        attr_i,
   input  logic [CNT_W-1:0] su_i,
   input  logic [CNT_W-1:0] ho_i,
   input  logic [CNT_W-1:0] st_i,
   output pcc_state_e       state_o,
   output pcc_attr_t        attr_o,
   output logic             busy_o
);

   pcc_state_e       state_q;
   pcc_attr_t        attr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] st_q;
   logic [CNT_W-1:0] ho_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         attr_q  <= '0;
         cnt_q   <= '0;
         st_q    <= '0;
         ho_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_i) begin
                  attr_q <= attr_i;
                  st_q   <= st_i;
                  ho_q   <= ho_i;
                  if (su_i == '0) begin
                     state_q <= ST_STROBE;
                     cnt_q   <= st_i;
                  end else begin
                     state_q <= ST_SETUP;
                     cnt_q   <= su_i - CNT_W'(1);
                  end
               end
            end
            ST_SETUP: begin
               if (cnt_q == '0) begin
                  state_q <= ST_STROBE;
                  cnt_q   <= st_q;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_STROBE: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end else if (ready_i) begin
                  if (ho_q == '0) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_HOLD;
                     cnt_q   <= ho_q - CNT_W'(1);
                  end
               end
            end
            default: begin // ST_HOLD
               if (cnt_q == '0) state_q <= ST_IDLE;
               else             cnt_q   <= cnt_q - CNT_W'(1);
            end
         endcase
      end
   end

   assign state_o = state_q;
   assign attr_o  = attr_q;
   assign busy_o  = (state_q != ST_IDLE);

   AST_READY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STROBE && cnt_q == '0 && !ready_i) |=> (state_q == ST_STROBE)); // R5

   AST_BUSY_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(attr_q)); // R9

   AST_SETUP_TO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETUP) |=> (state_q == ST_SETUP || state_q == ST_STROBE)); // R2

endmodule

// File: rtl/pcc_pins.sv
`timescale 1ns/1ps
module pcc_pins
   import pcc_pkg::*;
#(
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  pcc_state_e state_i,
   input  pcc_attr_t  attr_i,
   output logic       ce1_n_o,
   output logic       ce2_n_o,
   output logic       oe_n_o,
   output logic       we_n_o,
   output logic       iord_n_o,
   output logic       iowr_n_o,
   output logic       reg_n_o
);

   logic active;
   logic strobe;

   assign active = (state_i != ST_IDLE);
   assign strobe = (state_i == ST_STROBE);

   assign oe_n_o   = !(strobe && !attr_i.io && !attr_i.wr);
   assign we_n_o   = !(strobe && !attr_i.io &&  attr_i.wr);
   assign iord_n_o = !(strobe &&  attr_i.io && !attr_i.wr);
   assign iowr_n_o = !(strobe &&  attr_i.io &&  attr_i.wr);
   assign reg_n_o  = !(active && attr_i.attr);

   if (ALLOW_WIDE) begin : g_wide
      assign ce1_n_o = !(active && (!attr_i.wide || attr_i.be[0]));
      assign ce2_n_o = !(active &&   attr_i.wide && attr_i.be[1]);
   end else begin : g_narrow
      assign ce1_n_o = !active;
      assign ce2_n_o = 1'b1;
   end

endmodule

// File: rtl/pcc_access_gen.sv
`timescale 1ns/1ps
module pcc_access_gen
   import pcc_pkg::*;
#(
   parameter int unsigned             BASE_W     = 4,
   parameter bit                      ALLOW_WIDE = 1'b1,
   parameter logic [MAP_N*MAP_FW-1:0] SETUP_MAP  = {8'd15, 8'd2, 8'd1, 8'd0},
   parameter logic [MAP_N*MAP_FW-1:0] HOLD_MAP   = {8'd15, 8'd2, 8'd1, 8'd0},
   parameter logic [MAP_N*MAP_FW-1:0] WAIT_MAP   = {8'd50, 8'd30, 8'd15, 8'd0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              io_i,
   input  logic              write_i,
   input  logic              attr_i,
   input  logic              wide_i,
   input  logic [1:0]        be_i,
   input  logic [1:0]        setup_code_i,
   input  logic [1:0]        hold_code_i,
   input  logic [1:0]        cwait_code_i,
   input  logic [BASE_W-1:0] base_wait_i,
   input  logic              ready_i,
   output logic              busy_o,
   output logic              ce1_n_o,
   output logic              ce2_n_o,
   output logic              oe_n_o,
   output logic              we_n_o,
   output logic              iord_n_o,
   output logic              iowr_n_o,
   output logic              reg_n_o
);

   localparam int unsigned SUM_MAX = (2**BASE_W - 1) + map_max(WAIT_MAP);
   localparam int unsigned EDGE_MAX = (map_max(SETUP_MAP) > map_max(HOLD_MAP)) ?
                                      map_max(SETUP_MAP) : map_max(HOLD_MAP);
   localparam int unsigned TOP_MAX = (SUM_MAX > EDGE_MAX) ? SUM_MAX : EDGE_MAX;
   localparam int unsigned CNT_W   = $clog2(TOP_MAX + 1);

   initial begin
      AST_CFG_BASE_W: assert (BASE_W >= 1 && BASE_W <= 8)
         else $error("base wait width out of range"); // R4
   end

   logic [CNT_W-1:0] su_cyc, ho_cyc, st_cyc;
   pcc_attr_t        req_attr, cur_attr;
   pcc_state_e       state;

   assign req_attr = '{io: io_i, wr: write_i, attr: attr_i, wide: wide_i, be: be_i};

   pcc_decode #(
      .BASE_W(BASE_W), .CNT_W(CNT_W),
      .SETUP_MAP(SETUP_MAP), .HOLD_MAP(HOLD_MAP), .WAIT_MAP(WAIT_MAP)
   ) u_decode (
      .su_code_i(setup_code_i),
      .ho_code_i(hold_code_i),
      .cw_code_i(cwait_code_i),
      .base_i   (base_wait_i),
      .su_o     (su_cyc),
      .ho_o     (ho_cyc),
      .st_o     (st_cyc)
   );

   pcc_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .ready_i(ready_i),
      .attr_i (req_attr),
      .su_i   (su_cyc),
      .ho_i   (ho_cyc),
      .st_i   (st_cyc),
      .state_o(state),
      .attr_o (cur_attr),
      .busy_o (busy_o)
   );

   pcc_pins #(.ALLOW_WIDE(ALLOW_WIDE)) u_pins (
      .state_i (state),
      .attr_i  (cur_attr),
      .ce1_n_o (ce1_n_o),
      .ce2_n_o (ce2_n_o),
      .oe_n_o  (oe_n_o),
      .we_n_o  (we_n_o),
      .iord_n_o(iord_n_o),
      .iowr_n_o(iowr_n_o),
      .reg_n_o (reg_n_o)
   );

   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~oe_n_o, ~we_n_o, ~iord_n_o, ~iowr_n_o}) <= 1); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (&{ce1_n_o, ce2_n_o, oe_n_o, we_n_o, iord_n_o, iowr_n_o, reg_n_o})); // R1

   AST_REG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(reg_n_o)); // R7

   AST_CE2_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !cur_attr.wide) |-> ce2_n_o); // R8

   AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !(&{oe_n_o, we_n_o, iord_n_o, iowr_n_o}) |-> (!ce1_n_o || !ce2_n_o)); // R8

endmodule

// File: tb/tb_pcc_access_gen.sv
`timescale 1ns/1ps
module tb_pcc_access_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_i = 1'b0, io_i = 1'b0, write_i = 1'b0, attr_i = 1'b0, wide_i = 1'b0;
   logic [1:0] be_i = 2'b00, setup_code_i = 2'd0, hold_code_i = 2'd0, cwait_code_i = 2'd0;
   logic [3:0] base_wait_i = 4'd0;
   logic       ready_i = 1'b1;
   logic       busy_o, ce1_n_o, ce2_n_o, oe_n_o, we_n_o, iord_n_o, iowr_n_o, reg_n_o;

   always #2.5 clk = ~clk;

   pcc_access_gen dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .io_i(io_i), .write_i(write_i),
      .attr_i(attr_i), .wide_i(wide_i), .be_i(be_i), .setup_code_i(setup_code_i),
      .hold_code_i(hold_code_i), .cwait_code_i(cwait_code_i), .base_wait_i(base_wait_i),
      .ready_i(ready_i), .busy_o(busy_o), .ce1_n_o(ce1_n_o), .ce2_n_o(ce2_n_o),
      .oe_n_o(oe_n_o), .we_n_o(we_n_o), .iord_n_o(iord_n_o), .iowr_n_o(iowr_n_o),
      .reg_n_o(reg_n_o)
   );

   typedef struct {
      int         su, st, ho, kind;
      logic [1:0] ce;     // {ce2_n, ce1_n} expected
      logic       rg;     // expected reg_n level
      string      stag;   // requirement for strobe length
   } exp_t;

   exp_t exp_q[$];
   int   total = 0, bad = 0;
   bit   finished = 0;

   int edge_map [4] = '{0, 1, 2, 15};
   int wait_map [4] = '{0, 15, 30, 50};

   task automatic chk(input string tag, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
      end
   endtask

   function automatic logic [3:0] strobes();
      return ~{iowr_n_o, iord_n_o, we_n_o, oe_n_o};
   endfunction

   // ---------------- monitor ----------------
   bit         in_acc = 0, seen = 0, mixed = 0, idle_bad = 0;
   int         nsu, nst, nho, kobs;
   logic [1:0] ce_obs;
   logic       rg_obs;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (busy_o) begin
            if (!in_acc) begin
               in_acc = 1; seen = 0; mixed = 0; nsu = 0; nst = 0; nho = 0; kobs = -1;
               ce_obs = {ce2_n_o, ce1_n_o}; rg_obs = reg_n_o;
            end else if ({ce2_n_o, ce1_n_o} != ce_obs || reg_n_o != rg_obs) begin
               mixed = 1;
            end
            if (strobes() != 4'b0) begin
               int k;
               seen = 1; nst++;
               k = strobes()[0] ? 0 : strobes()[1] ? 1 : strobes()[2] ? 2 : 3;
               if ($countones(strobes()) > 1) mixed = 1;
               if (kobs == -1) kobs = k; else if (k != kobs) mixed = 1;
            end else if (!seen) nsu++;
            else nho++;
         end else begin
            if (!(&{ce1_n_o, ce2_n_o, oe_n_o, we_n_o, iord_n_o, iowr_n_o, reg_n_o}) && !idle_bad) begin
               idle_bad = 1;
               chk("R1 idle pins high", 0, 1);
            end
            if (in_acc) begin
               in_acc = 0;
               if (exp_q.size() == 0) begin
                  chk("R9 unexpected access", 1, 0);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk("R2 setup cycles", nsu, e.su);
                  chk({e.stag, " strobe cycles"}, nst, e.st);
                  chk("R3 hold cycles", nho, e.ho);
                  chk("R6 strobe kind", kobs, e.kind);
                  chk("R6 single steady strobe / R7 R8 steady pins", int'(mixed), 0);
                  chk("R8 card enables", int'(ce_obs), int'(e.ce));
                  chk("R7 register select", int'(rg_obs), int'(e.rg));
               end
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic access(input logic [1:0] su_c, ho_c, cw_c, input int base,
                         input logic io, wr, at, wd, input logic [1:0] be,
                         input int extra, input bit poke);
      exp_t e;
      e.su   = edge_map[su_c];
      e.ho   = edge_map[ho_c];
      e.st   = base + wait_map[cw_c] + 1 + extra;
      e.kind = {io, wr} == 2'b00 ? 0 : {io, wr} == 2'b01 ? 1 : {io, wr} == 2'b10 ? 2 : 3;
      e.ce   = wd ? ~be : 2'b10;
      e.rg   = !at;
      e.stag = (extra > 0) ? "R5" : "R4";
      exp_q.push_back(e);
      @(negedge clk);
      setup_code_i = su_c; hold_code_i = ho_c; cwait_code_i = cw_c; base_wait_i = 4'(base);
      io_i = io; write_i = wr; attr_i = at; wide_i = wd; be_i = be;
      req_i = 1'b1;
      if (extra > 0) ready_i = 1'b0;
      @(negedge clk);
      // scramble inputs: the running access must not follow them (R9)
      req_i = poke;
      io_i = !io; write_i = !wr; attr_i = !at; wide_i = !wd; be_i = ~be;
      setup_code_i = ~su_c; hold_code_i = ~ho_c; cwait_code_i = ~cw_c; base_wait_i = ~4'(base);
      if (poke) begin
         @(negedge clk);
         req_i = 1'b0;
      end
      if (extra > 0) begin
         while (strobes() == 4'b0) @(negedge clk);
         repeat (base + wait_map[cw_c] + extra) @(negedge clk);
         ready_i = 1'b1;
      end
      while (busy_o) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset busy", int'(busy_o), 0);
      chk("R1 reset pins", int'({ce1_n_o, ce2_n_o, oe_n_o, we_n_o, iord_n_o, iowr_n_o, reg_n_o}), 7'h7f);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // su ho cw base io wr attr wide be extra poke
      access(2'd0, 2'd0, 2'd0, 0,  1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 0, 0); // R4 min, attr read, narrow
      access(2'd1, 2'd1, 2'd0, 3,  1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 0, 0); // mem write 16-bit
      access(2'd2, 2'd2, 2'd1, 0,  1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 0, 0); // IO read low byte
      access(2'd3, 2'd3, 2'd2, 5,  1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 0, 0); // IO write high byte, 15/15
      access(2'd1, 2'd2, 2'd3, 15, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 0, 0); // max wait, narrow R8
      access(2'd1, 2'd0, 2'd0, 2,  1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 3, 0); // R5 stretch 3
      access(2'd0, 2'd1, 2'd0, 0,  1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1, 0); // R5 stretch 1, no setup
      access(2'd2, 2'd1, 2'd1, 4,  1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 0, 1); // R9 request while busy
      access(2'd3, 2'd0, 2'd0, 7,  1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 0, 1); // R7 attr write
      access(2'd0, 2'd3, 2'd1, 1,  1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 0, 0); // R3 long hold
      repeat (5) @(negedge clk);
      chk("R9 leftover expected accesses", exp_q.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule